// File: doc/BRIEF.md
# Paged Expanded Data RAM Controller

This block sits beside an 8-bit microcontroller core and owns a 768-byte data RAM. The core reaches that RAM only through its external-data move cycles. The block looks at each such access and decides where it goes. It either serves the access from the on-chip RAM or passes it, registered, to the external bus interface.

Two special-function registers steer that decision:
- A window-select register picks which 256-byte slice an 8-bit register-indirect access lands in.
- A control register holds three fields: the RAM enable, a sticky flag that records a watchdog-caused reset, and a bit that silences the address-latch strobe to reduce emissions.

The core drives the SFR port and the access port. The watchdog timer raises a one-cycle reset request, which resets the control fields but leaves the flag set so that firmware can find the cause. Every result leaves the block through a register.

Top module: `xram_page_ctrl`

## Requirements
- R1: After the synchronous `rst`, the window select is 0, the control register reads 0x00, `xd_hit_o` and `ext_req_o` are low, and `ale_o` is low.
- R2: The window-select register is at SFR address 0x85. Its bits 1:0 read back as written. Bits 7:2 always read 0, and writing them has no effect.
- R3: The control register is at SFR address 0xBF, with these fields:
  - bit 7: the watchdog flag
  - bit 1: the RAM enable
  - bit 0: the strobe inhibit

  Bits 6:2 always read 0. A read of any other SFR address returns 0x00.
- R4: With the enable set, an 8-bit indirect access (`xd_ind_i`=1) goes to RAM byte `window*256 + xd_addr_i[7:0]`. Window value 3 is treated as window 2.
- R5: With the enable set, a 16-bit pointer access hits RAM when `xd_addr_i` is below 0x0300. Otherwise it is forwarded to the external bus with the address unchanged.
- R6: With the enable clear, every access is forwarded to the external bus, with its address, write flag and write data. RAM contents are not changed.
- R7: Results appear one cycle after the access:
  - A RAM read raises `xd_hit_o` and presents the byte on `xd_rdata_o`.
  - A forwarded access raises `ext_req_o`.
  - A RAM write raises neither.
- R8: A `wdt_rst_i` cycle sets the watchdog flag and clears the window select, the enable and the inhibit. It blocks any access in that cycle and keeps the RAM contents.
- R9: The watchdog flag is cleared by `rst` or by a software write of 0 to bit 7. Software may also write it to 1.
- R10: `ale_o` is `ale_clk_i` delayed by one cycle while the inhibit is 0, and is held at 0 while the inhibit is 1.
- R11: `sfr_rdata_o` returns, one cycle after `sfr_addr_i` is presented, the register contents as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wdt_rst_i | input | 1 | Watchdog-caused reset request, one cycle |
| sfr_addr_i | input | 8 | SFR address for read and write |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | Registered SFR read data |
| xd_req_i | input | 1 | External-data access request |
| xd_wr_i | input | 1 | Access is a write (1) or read (0) |
| xd_ind_i | input | 1 | 8-bit register-indirect access (1) or 16-bit pointer (0) |
| xd_addr_i | input | 16 | Access address (upper byte supplied by the core) |
| xd_wdata_i | input | 8 | Access write data |
| xd_rdata_o | output | 8 | RAM read data, valid with `xd_hit_o` |
| xd_hit_o | output | 1 | A RAM read completed in the previous cycle |
| ext_req_o | output | 1 | Forwarded access to external bus |
| ext_wr_o | output | 1 | Forwarded access is a write |
| ext_addr_o | output | 16 | Forwarded address |
| ext_wdata_o | output | 8 | Forwarded write data |
| ale_clk_i | input | 1 | Address-latch strobe from the core |
| ale_o | output | 1 | Gated, registered address-latch strobe |

## Verification
Every result is due exactly one rising edge after its stimulus. This covers:
- SFR read data
- RAM read data with its hit flag
- the forwarded external request
- the gated strobe

The bench therefore changes inputs on a falling edge and samples outputs on the following falling edge. The single rising edge between them is the only one that can move the result. A register update and its readback take two such steps: the write edge first, then the read edge.

Watchdog and reset pulses are held for exactly one rising edge. The state they leave behind is read through the SFR port and the RAM path on the next steps.

// File: rtl/xram_pkg.sv
package xram_pkg;
  typedef enum logic [0:0] {
    ROUTE_EXT = 1'b0,
    ROUTE_INT = 1'b1
  } route_e;

  localparam int CTRL_WDF_BIT = 7;
  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_INH_BIT = 0;
endpackage

// File: rtl/xram_regs.sv
module xram_regs
  import xram_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          PAGE_W    = 2,
  parameter logic [7:0]  PAGE_ADDR = 8'h85,
  parameter logic [7:0]  CTRL_ADDR = 8'hBF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_rst_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              en_o,
  output logic              wdf_o,
  output logic              inh_o
);
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^sfr_wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_o <= '0;
      en_o   <= 1'b0;
      wdf_o  <= 1'b0;
      inh_o  <= 1'b0;
    end else if (wdt_rst_i) begin
      page_o <= '0;
      en_o   <= 1'b0;
      wdf_o  <= 1'b1;
      inh_o  <= 1'b0;
    end else if (sfr_wr_i) begin
      if (sfr_addr_i == PAGE_ADDR) begin
        page_o <= sfr_wdata_i[PAGE_W-1:0];
      end
      if (sfr_addr_i == CTRL_ADDR) begin
        wdf_o <= sfr_wdata_i[CTRL_WDF_BIT];
        en_o  <= sfr_wdata_i[CTRL_EN_BIT];
        inh_o <= sfr_wdata_i[CTRL_INH_BIT];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (sfr_addr_i == PAGE_ADDR) begin
      rd_next[PAGE_W-1:0] = page_o;
    end else if (sfr_addr_i == CTRL_ADDR) begin
      rd_next[CTRL_WDF_BIT] = wdf_o;
      rd_next[CTRL_EN_BIT]  = en_o;
      rd_next[CTRL_INH_BIT] = inh_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sfr_rdata_o <= '0;
    else     sfr_rdata_o <= rd_next;
  end
endmodule

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 2,
  parameter int PAGE_COUNT = 3,
  parameter int PAGE_BYTES = 256,
  parameter int MEM_DEPTH  = PAGE_COUNT * PAGE_BYTES,
  parameter int MEM_AW     = $clog2(MEM_DEPTH)
) (
  input  logic              en_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              ind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output route_e            route_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

  logic [PAGE_W-1:0] page_eff;

  always_comb begin
    page_eff = (page_i > LAST_PAGE) ? LAST_PAGE : page_i;
    route_o    = ROUTE_EXT;
    mem_addr_o = '0;
    if (en_i) begin
      if (ind_i) begin
        route_o    = ROUTE_INT;
        mem_addr_o = MEM_AW'(page_eff) * MEM_AW'(PAGE_BYTES)
                   + MEM_AW'(addr_i[OFF_W-1:0]);
      end else if (addr_i < ADDR_W'(MEM_DEPTH)) begin
        route_o    = ROUTE_INT;
        mem_addr_o = addr_i[MEM_AW-1:0];
      end
    end
  end
endmodule

// File: rtl/xram_mem.sv
module xram_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 768,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[addr_i] <= wdata_i;
    rdata_o <= store[addr_i];
  end
endmodule

// File: rtl/xram_page_ctrl.sv
module xram_page_ctrl
  import xram_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         ADDR_W     = 16,
  parameter int         PAGE_W     = 2,
  parameter int         PAGE_COUNT = 3,
  parameter int         PAGE_BYTES = 256,
  parameter logic [7:0] PAGE_ADDR  = 8'h85,
  parameter logic [7:0] CTRL_ADDR  = 8'hBF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_rst_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  input  logic              xd_req_i,
  input  logic              xd_wr_i,
  input  logic              xd_ind_i,
  input  logic [ADDR_W-1:0] xd_addr_i,
  input  logic [DATA_W-1:0] xd_wdata_i,
  output logic [DATA_W-1:0] xd_rdata_o,
  output logic              xd_hit_o,
  output logic              ext_req_o,
  output logic              ext_wr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic              ale_clk_i,
  output logic              ale_o
);
  localparam int MEM_DEPTH = PAGE_COUNT * PAGE_BYTES;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);

  logic [PAGE_W-1:0] page_q;
  logic              en_q;
  logic              wdf_q;
  logic              inh_q;
  route_e            route;
  logic [MEM_AW-1:0] mem_addr;
  logic              acc_ok;
  logic              mem_we;

  xram_regs #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .PAGE_ADDR(PAGE_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wdt_rst_i(wdt_rst_i),
    .sfr_addr_i(sfr_addr_i), .sfr_wr_i(sfr_wr_i),
    .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o),
    .page_o(page_q), .en_o(en_q), .wdf_o(wdf_q), .inh_o(inh_q)
  );

  xram_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_COUNT(PAGE_COUNT),
    .PAGE_BYTES(PAGE_BYTES), .MEM_DEPTH(MEM_DEPTH), .MEM_AW(MEM_AW)
  ) u_decode (
    .en_i(en_q), .page_i(page_q), .ind_i(xd_ind_i), .addr_i(xd_addr_i),
    .route_o(route), .mem_addr_o(mem_addr)
  );

  assign acc_ok = xd_req_i & ~wdt_rst_i & ~rst;
  assign mem_we = acc_ok & xd_wr_i & (route == ROUTE_INT);

  xram_mem #(
    .DATA_W(DATA_W), .DEPTH(MEM_DEPTH), .AW(MEM_AW)
  ) u_mem (
    .clk(clk), .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(xd_wdata_i), .rdata_o(xd_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xd_hit_o    <= 1'b0;
      ext_req_o   <= 1'b0;
      ext_wr_o    <= 1'b0;
      ext_addr_o  <= '0;
      ext_wdata_o <= '0;
      ale_o       <= 1'b0;
    end else begin
      xd_hit_o  <= acc_ok & ~xd_wr_i & (route == ROUTE_INT);
      ext_req_o <= acc_ok & (route == ROUTE_EXT);
      if (acc_ok && route == ROUTE_EXT) begin
        ext_wr_o    <= xd_wr_i;
        ext_addr_o  <= xd_addr_i;
        ext_wdata_o <= xd_wdata_i;
      end
      ale_o <= ale_clk_i & ~inh_q;
    end
  end
endmodule

// File: rtl/xram_page_ctrl_chk.sv
module xram_page_ctrl_chk #(
  parameter int         ADDR_W    = 16,
  parameter int         PAGE_W    = 2,
  parameter int         MEM_DEPTH = 768,
  parameter logic [7:0] CTRL_ADDR = 8'hBF
) (
  input logic              clk,
  input logic              rst,
  input logic              wdt_rst_i,
  input logic [7:0]        sfr_addr_i,
  input logic              sfr_wr_i,
  input logic [7:0]        sfr_wdata_i,
  input logic              xd_req_i,
  input logic              xd_ind_i,
  input logic [ADDR_W-1:0] xd_addr_i,
  input logic              xd_hit_o,
  input logic              ext_req_o,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic              ale_o,
  input logic [PAGE_W-1:0] page_q,
  input logic              en_q,
  input logic              wdf_q,
  input logic              inh_q
);
  assert_wdt_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_i |=> (wdf_q && !en_q && !inh_q && page_q == '0));

  assert_ale_held_low_R10: assert property (@(posedge clk) disable iff (rst)
    inh_q |=> !ale_o);

  assert_disabled_goes_ext_R6: assert property (@(posedge clk) disable iff (rst)
    (xd_req_i && !en_q && !wdt_rst_i) |=> (ext_req_o && !xd_hit_o));

  assert_high_addr_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (xd_req_i && !xd_ind_i && en_q && !wdt_rst_i && xd_addr_i >= ADDR_W'(MEM_DEPTH))
      |=> (ext_req_o && ext_addr_o == $past(xd_addr_i)));

  assert_single_target_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xd_hit_o, ext_req_o}));

  assert_flag_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr_i && sfr_addr_i == CTRL_ADDR && !sfr_wdata_i[7] && !wdt_rst_i) |=> !wdf_q);
endmodule

bind xram_page_ctrl xram_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
  .MEM_DEPTH(PAGE_COUNT * PAGE_BYTES), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wdt_rst_i(wdt_rst_i),
  .sfr_addr_i(sfr_addr_i), .sfr_wr_i(sfr_wr_i), .sfr_wdata_i(sfr_wdata_i),
  .xd_req_i(xd_req_i), .xd_ind_i(xd_ind_i), .xd_addr_i(xd_addr_i),
  .xd_hit_o(xd_hit_o), .ext_req_o(ext_req_o), .ext_addr_o(ext_addr_o),
  .ale_o(ale_o), .page_q(page_q), .en_q(en_q), .wdf_q(wdf_q), .inh_q(inh_q)
);

// File: tb/test_xram_page_ctrl.sv
module test_xram_page_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PG = 8'h85;
  localparam logic [7:0] CT = 8'hBF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wdt_rst_i = 1'b0;
  logic [7:0]  sfr_addr_i = '0;
  logic        sfr_wr_i = 1'b0;
  logic [7:0]  sfr_wdata_i = '0;
  logic [7:0]  sfr_rdata_o;
  logic        xd_req_i = 1'b0, xd_wr_i = 1'b0, xd_ind_i = 1'b0;
  logic [15:0] xd_addr_i = '0;
  logic [7:0]  xd_wdata_i = '0;
  logic [7:0]  xd_rdata_o;
  logic        xd_hit_o, ext_req_o, ext_wr_o;
  logic [15:0] ext_addr_o;
  logic [7:0]  ext_wdata_o;
  logic        ale_clk_i = 1'b0;
  logic        ale_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] model [768];
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  xram_page_ctrl i_xram_page_ctrl (
    .clk(clk), .rst(rst), .wdt_rst_i(wdt_rst_i),
    .sfr_addr_i(sfr_addr_i), .sfr_wr_i(sfr_wr_i), .sfr_wdata_i(sfr_wdata_i),
    .sfr_rdata_o(sfr_rdata_o),
    .xd_req_i(xd_req_i), .xd_wr_i(xd_wr_i), .xd_ind_i(xd_ind_i),
    .xd_addr_i(xd_addr_i), .xd_wdata_i(xd_wdata_i), .xd_rdata_o(xd_rdata_o),
    .xd_hit_o(xd_hit_o), .ext_req_o(ext_req_o), .ext_wr_o(ext_wr_o),
    .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o),
    .ale_clk_i(ale_clk_i), .ale_o(ale_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + ((a >> 8) * 11) + 5);
  endfunction

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_addr_i = a; sfr_wdata_i = d; sfr_wr_i = 1'b1;
    @(negedge clk);
    sfr_wr_i = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    sfr_addr_i = a;
    @(negedge clk);
    d = sfr_rdata_o;
  endtask

  task automatic xd(input logic wr, input logic ind, input logic [15:0] a,
                    input logic [7:0] d);
    xd_req_i = 1'b1; xd_wr_i = wr; xd_ind_i = ind; xd_addr_i = a; xd_wdata_i = d;
    @(negedge clk);
    xd_req_i = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_rst_i = 1'b1;
    @(negedge clk);
    wdt_rst_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "hit", 32'(xd_hit_o), 0);
    chk("R1", "ext_req", 32'(ext_req_o), 0);
    chk("R1", "ale", 32'(ale_o), 0);
    sfr_read(PG, rv); chk("R1", "page reg", 32'(rv), 0);
    sfr_read(CT, rv); chk("R1", "ctrl reg", 32'(rv), 0);

    // R2 / R3 unused bits and other addresses
    sfr_write(PG, 8'hFF); sfr_read(PG, rv); chk("R2", "page unused bits", 32'(rv), 32'h03);
    sfr_write(PG, 8'hFE); sfr_read(PG, rv); chk("R2", "page value", 32'(rv), 32'h02);
    sfr_write(CT, 8'h7C); sfr_read(CT, rv); chk("R3", "ctrl unused bits", 32'(rv), 32'h00);
    sfr_write(CT, 8'hFF); sfr_read(CT, rv); chk("R3", "ctrl all", 32'(rv), 32'h83);
    sfr_read(8'h90, rv); chk("R3", "other sfr", 32'(rv), 32'h00);
    // R11 read returns value before same-edge write
    sfr_addr_i = PG; sfr_wdata_i = 8'h01; sfr_wr_i = 1'b1;
    @(negedge clk); sfr_wr_i = 1'b0;
    chk("R11", "read old value", 32'(sfr_rdata_o), 32'h02);
    sfr_read(PG, rv); chk("R11", "read new value", 32'(rv), 32'h01);

    // R10 inhibit set (ctrl = 0x83)
    ale_clk_i = 1'b1; @(negedge clk); chk("R10", "ale inhibited", 32'(ale_o), 0);
    sfr_write(CT, 8'h02);
    ale_clk_i = 1'b1; @(negedge clk); chk("R10", "ale high", 32'(ale_o), 1);
    ale_clk_i = 1'b0; @(negedge clk); chk("R10", "ale low", 32'(ale_o), 0);

    // R5 fill RAM via pointer writes, enabled
    for (int a = 0; a < 768; a++) begin
      xd(1'b1, 1'b0, 16'(a), pat(a));
      model[a] = pat(a);
      if (a % 97 == 0) begin
        chk("R7", "write no hit", 32'(xd_hit_o), 0);
        chk("R7", "write no ext", 32'(ext_req_o), 0);
      end
    end
    // R4 indirect sweep over all windows
    for (int p = 0; p < 4; p++) begin
      sfr_write(PG, 8'(p));
      for (int o = 0; o < 256; o++) begin
        int idx;
        idx = ((p > 2) ? 2 : p) * 256 + o;
        xd(1'b0, 1'b1, {8'h5A, 8'(o)}, 8'h00);
        chk("R4", "indirect hit", 32'(xd_hit_o), 1);
        chk("R4", "indirect data", 32'(xd_rdata_o), 32'(model[idx]));
      end
    end
    // R4 indirect writes, window 1 and window 3 (acts as 2)
    sfr_write(PG, 8'h01); xd(1'b1, 1'b1, 16'h0005, 8'h5C); model[16'h105] = 8'h5C;
    sfr_write(PG, 8'h03); xd(1'b1, 1'b1, 16'h00F0, 8'hC3); model[16'h2F0] = 8'hC3;
    xd(1'b0, 1'b0, 16'h0105, 8'h00); chk("R4", "indirect write w1", 32'(xd_rdata_o), 32'h5C);
    xd(1'b0, 1'b0, 16'h02F0, 8'h00); chk("R4", "indirect write w3", 32'(xd_rdata_o), 32'hC3);
    // R5 pointer read sweep and boundary
    for (int a = 0; a < 768; a += 13) begin
      xd(1'b0, 1'b0, 16'(a), 8'h00);
      chk("R5", "pointer data", 32'(xd_rdata_o), 32'(model[a]));
    end
    xd(1'b0, 1'b0, 16'h02FF, 8'h00);
    chk("R5", "last byte hit", 32'(xd_hit_o), 1);
    chk("R5", "last byte data", 32'(xd_rdata_o), 32'(model[767]));
    xd(1'b0, 1'b0, 16'h0300, 8'h00);
    chk("R5", "0x300 ext", 32'(ext_req_o), 1);
    chk("R5", "0x300 no hit", 32'(xd_hit_o), 0);
    chk("R5", "0x300 addr", 32'(ext_addr_o), 32'h0300);
    xd(1'b1, 1'b0, 16'hFFFF, 8'h99);
    chk("R5", "high write ext", 32'(ext_req_o), 1);
    chk("R5", "high write flag", 32'(ext_wr_o), 1);
    chk("R5", "high write data", 32'(ext_wdata_o), 32'h99);

    // R6 disabled
    sfr_write(CT, 8'h00);
    xd(1'b1, 1'b0, 16'h0010, 8'hAA);
    chk("R6", "dis ext", 32'(ext_req_o), 1);
    chk("R6", "dis wr", 32'(ext_wr_o), 1);
    chk("R6", "dis addr", 32'(ext_addr_o), 32'h0010);
    chk("R6", "dis wdata", 32'(ext_wdata_o), 32'hAA);
    xd(1'b1, 1'b1, 16'h1222, 8'hBB);
    chk("R6", "dis ind addr", 32'(ext_addr_o), 32'h1222);
    xd(1'b0, 1'b1, 16'h0022, 8'h00);
    chk("R6", "dis read ext", 32'(ext_req_o), 1);
    chk("R6", "dis read no hit", 32'(xd_hit_o), 0);
    chk("R6", "dis read flag", 32'(ext_wr_o), 0);
    sfr_write(CT, 8'h02);
    xd(1'b0, 1'b0, 16'h0010, 8'h00);
    chk("R6", "ram untouched 0x10", 32'(xd_rdata_o), 32'(model[16'h10]));
    xd(1'b0, 1'b0, 16'h0222, 8'h00);
    chk("R6", "ram untouched 0x222", 32'(xd_rdata_o), 32'(model[16'h222]));

    // R8 watchdog reset
    sfr_write(PG, 8'h02); sfr_write(CT, 8'h03);
    xd_req_i = 1'b1; xd_wr_i = 1'b1; xd_ind_i = 1'b0; xd_addr_i = 16'h0040; xd_wdata_i = 8'h11;
    pulse_wdt(); xd_req_i = 1'b0;
    chk("R8", "blocked access no ext", 32'(ext_req_o), 0);
    sfr_read(CT, rv); chk("R8", "ctrl after wdt", 32'(rv), 32'h80);
    sfr_read(PG, rv); chk("R8", "page after wdt", 32'(rv), 32'h00);
    sfr_write(CT, 8'h82);
    xd(1'b0, 1'b0, 16'h0040, 8'h00);
    chk("R8", "ram kept", 32'(xd_rdata_o), 32'(model[16'h40]));
    // R9 flag clearing
    sfr_write(CT, 8'h02); sfr_read(CT, rv); chk("R9", "sw clear", 32'(rv), 32'h02);
    sfr_write(CT, 8'h80); sfr_read(CT, rv); chk("R9", "sw set", 32'(rv), 32'h80);
    pulse_wdt();
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    sfr_read(CT, rv); chk("R9", "por clear", 32'(rv), 32'h00);
    chk("R1", "ale after rst", 32'(ale_o), 0);

    finish_run();
  end
endmodule